// File: doc/BRIEF.md
# Nested Priority Vectored Interrupt Controller

The controller gathers 32 interrupt request lines and drives two processor request outputs: a normal request (`irq_o`) and a fast request (`fiq_o`). Each source has a 3-bit priority, an edge or level trigger choice and a 32-bit vector. Software enables sources, sets or clears edge-triggered pending bits and moves sources to the fast request path. It fetches the vector of the winning source through a single-cycle register port. Every fetch that acknowledges a source pushes that source and its priority onto a hardware nesting stack. An end-of-interrupt write pops the stack. A normal request is raised only when the best waiting source outranks the level currently in service.

The register port uses word addresses (`bus_addr`). Reads are combinational and take effect at the clock edge. The map is as follows:

- 0x00–0x1F: source mode.
- 0x20–0x3F: source vector.
- 0x40: enable mask (write ones to set).
- 0x41: disable mask (write ones to clear).
- 0x42: force to fast path (write ones to set).
- 0x43: remove force (write ones to clear).
- 0x44: set pending.
- 0x45: clear pending.
- 0x46: end of interrupt.
- 0x47: debug control.
- 0x48: spurious vector.
- 0x49: normal vector fetch.
- 0x4A: fast vector fetch.
- 0x4B: in-service source.
- 0x4C: pending read.
- 0x4D: mask read.
- 0x4E: force read.
- 0x4F: core status.

The command addresses and all unused addresses read as 0.

Top module: `prio_vec_intc`

## Requirements
- R1: After reset all mode, vector, pending, mask, force, spurious and debug state is zero, the stack is empty, both outputs are low and every register reads 0.
- R2: A mode word keeps the priority in bits [2:0] (7 highest) and the trigger in bit 5 (1 edge, 0 level). It reads back with all other bits zero.
- R3: A level source's pending bit follows its input. An edge source's pending bit is set by a rising input and stays set until acknowledged or cleared.
- R4: The set-pending and clear-pending commands change only bits of edge-triggered sources. The enable, disable, force and unforce commands set or clear the ones written in the mask or force register.
- R5: Arbitration considers sources 1 to 31 that are pending, enabled and not forced. The highest priority wins, and among equal priorities the lowest source number wins.
- R6: `fiq_o` and core status bit 0 are high when any pending, enabled source is source 0 or a forced source.
- R7: `irq_o` and core status bit 1 are high when a source takes part in arbitration and either the stack is empty or the winner's priority is strictly above the priority on top of the stack.
- R8: With debug control bit 1 set, both outputs are low and core status reads 0.
- R9: A normal vector fetch returns the winner's vector, or the spurious vector when nothing wins. With debug control bit 0 clear, the fetch also pushes the winner.
- R10: With debug control bit 0 set, a normal vector fetch has no side effect, and a write to the fetch address performs the push instead.
- R11: A push happens only when the stack holds fewer than 8 entries and the winner is not source 0. It clears the pending bit of an edge-triggered winner.
- R12: An end-of-interrupt write pops a non-empty stack and is ignored on an empty one. The in-service read returns the source number on top of the stack, or 0 when empty.
- R13: A fast vector fetch works as follows. If source 0 is pending, it returns vector 0 and clears that pending bit. Otherwise, if any forced source is pending, it returns vector 0 with no side effect. Otherwise it returns the spurious vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 32 | Interrupt source lines |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (arms read side effects) |
| bus_addr | input | 7 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The bench targets the following corner cases:

- **Equal-priority ties.** A design that scanned the wrong way would hand out the higher-numbered vector.
- **Equal-priority preemption.** A design comparing with "greater or equal" would re-raise `irq_o` while the same level is still in service.
- **Stack overflow and underflow.** A broken bound would wrap the depth and report a stale source.
- **Set and clear commands on level sources.** A design that let these commands through would fabricate or lose level requests.
- **Protect mode.** A design that pushed on reads in protect mode would nest silently.
- **Fast fetch without source 0.** A design that cleared pending bits here would drop forced requests.

A long randomized phase then compares every output and read against a reference model on each cycle.

// File: rtl/prio_vec_intc.sv
module prio_vec_intc #(
  parameter int DEPTH = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] src_i,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [6:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq_o,
  output logic        fiq_o
);
  localparam int NSRC = 32;
  localparam int DW = $clog2(DEPTH + 1);
  localparam int IW = $clog2(DEPTH);
  localparam logic [6:0] A_EN = 7'h40, A_DIS = 7'h41, A_FEN = 7'h42, A_FDIS = 7'h43;
  localparam logic [6:0] A_SET = 7'h44, A_CLR = 7'h45, A_EOI = 7'h46, A_DBG = 7'h47;
  localparam logic [6:0] A_SPUR = 7'h48, A_IVEC = 7'h49, A_FVEC = 7'h4A, A_TOP = 7'h4B;
  localparam logic [6:0] A_PEND = 7'h4C, A_MASK = 7'h4D, A_FORCE = 7'h4E, A_CORE = 7'h4F;

  logic [2:0]  prio_q [NSRC];
  logic [31:0] vec_q  [NSRC];
  logic [31:0] edge_q, pend_q, mask_q, force_q, spur_q, src_q, pend_d;
  logic [1:0]  dbg_q;
  logic [4:0]  stk_src [DEPTH];
  logic [2:0]  stk_pri [DEPTH];
  logic [DW-1:0] depth_q;

  logic [4:0]  win_id;
  logic [2:0]  win_pri;
  logic [31:0] req, fast_set, arb;
  logic [IW-1:0] top_idx;
  logic        stk_empty, stk_full, push_req, do_push, rd_fvec;

  assign req       = pend_q & mask_q;
  assign fast_set  = force_q | 32'h1;
  assign arb       = req & ~fast_set;
  assign stk_empty = (depth_q == '0);
  assign stk_full  = (depth_q == DW'(DEPTH));
  assign top_idx   = IW'(depth_q - DW'(1));

  always_comb begin
    win_id  = '0;
    win_pri = '0;
    for (int i = NSRC - 1; i >= 1; i--)
      if (arb[i] && prio_q[i] >= win_pri) begin
        win_id  = 5'(i);
        win_pri = prio_q[i];
      end
  end

  assign fiq_o = !dbg_q[1] && |(req & fast_set);
  assign irq_o = !dbg_q[1] && |arb && (stk_empty || win_pri > stk_pri[top_idx]);

  assign push_req = dbg_q[0] ? (bus_wr && bus_addr == A_IVEC) : (bus_rd && bus_addr == A_IVEC);
  assign do_push  = push_req && !stk_full && win_id != '0;
  assign rd_fvec  = bus_rd && bus_addr == A_FVEC;

  always_comb begin
    pend_d = pend_q;
    if (bus_wr && bus_addr == A_SET) pend_d = pend_d | (bus_wdata & edge_q);
    if (bus_wr && bus_addr == A_CLR) pend_d = pend_d & ~(bus_wdata & edge_q);
    if (do_push && edge_q[win_id]) pend_d[win_id] = 1'b0;
    if (rd_fvec && pend_q[0]) pend_d[0] = 1'b0;
    pend_d = pend_d | (src_i & ~src_q & edge_q);
    pend_d = (pend_d & edge_q) | (src_i & ~edge_q);
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr[6:5] == 2'b00)
      bus_rdata = {26'b0, edge_q[bus_addr[4:0]], 2'b0, prio_q[bus_addr[4:0]]};
    else if (bus_addr[6:5] == 2'b01)
      bus_rdata = vec_q[bus_addr[4:0]];
    else
      case (bus_addr)
        A_IVEC:  bus_rdata = (win_id == '0) ? spur_q : vec_q[win_id];
        A_FVEC:  bus_rdata = (pend_q[0] || |(pend_q & force_q)) ? vec_q[0] : spur_q;
        A_TOP:   bus_rdata = stk_empty ? 32'h0 : {27'b0, stk_src[top_idx]};
        A_PEND:  bus_rdata = pend_q;
        A_MASK:  bus_rdata = mask_q;
        A_FORCE: bus_rdata = force_q;
        A_CORE:  bus_rdata = {30'b0, irq_o, fiq_o};
        A_DBG:   bus_rdata = {30'b0, dbg_q};
        A_SPUR:  bus_rdata = spur_q;
        default: bus_rdata = '0;
      endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NSRC; i++) begin
        prio_q[i] <= '0;
        vec_q[i]  <= '0;
      end
      for (int j = 0; j < DEPTH; j++) begin
        stk_src[j] <= '0;
        stk_pri[j] <= '0;
      end
      edge_q  <= '0;
      pend_q  <= '0;
      mask_q  <= '0;
      force_q <= '0;
      spur_q  <= '0;
      src_q   <= '0;
      dbg_q   <= '0;
      depth_q <= '0;
    end else begin
      pend_q <= pend_d;
      src_q  <= src_i;
      if (bus_wr) begin
        if (bus_addr[6:5] == 2'b00) begin
          prio_q[bus_addr[4:0]] <= bus_wdata[2:0];
          edge_q[bus_addr[4:0]] <= bus_wdata[5];
        end
        if (bus_addr[6:5] == 2'b01) vec_q[bus_addr[4:0]] <= bus_wdata;
        case (bus_addr)
          A_EN:    mask_q  <= mask_q | bus_wdata;
          A_DIS:   mask_q  <= mask_q & ~bus_wdata;
          A_FEN:   force_q <= force_q | bus_wdata;
          A_FDIS:  force_q <= force_q & ~bus_wdata;
          A_DBG:   dbg_q   <= bus_wdata[1:0];
          A_SPUR:  spur_q  <= bus_wdata;
          A_EOI:   if (!stk_empty) depth_q <= depth_q - DW'(1);
          default: ;
        endcase
      end
      if (do_push) begin
        stk_src[IW'(depth_q)] <= win_id;
        stk_pri[IW'(depth_q)] <= win_pri;
        depth_q <= depth_q + DW'(1);
      end
    end
  end

  AST_DEPTH_BOUND: assert property (@(posedge clk) disable iff (!rst_n) depth_q <= DW'(DEPTH)); // R11
  AST_PUSH_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
    do_push |=> depth_q == $past(depth_q) + DW'(1)); // R9
  AST_POP_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_EOI && stk_empty) |=> depth_q == '0); // R12
  AST_EDGE_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (do_push && edge_q[win_id] && !(src_i[win_id] && !src_q[win_id])) |=> !pend_q[$past(win_id)]); // R11
  AST_GMASK_MUTE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_DBG && bus_wdata[1]) |=> (!irq_o && !fiq_o)); // R8
  AST_FAST_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fvec && pend_q[0] && edge_q[0] && !(src_i[0] && !src_q[0])) |=> !pend_q[0]); // R13
endmodule

// File: tb/test_prio_vec_intc.sv
`timescale 1ns/1ps
module test_prio_vec_intc;
  localparam logic [6:0] A_EN = 7'h40, A_DIS = 7'h41, A_FEN = 7'h42, A_FDIS = 7'h43;
  localparam logic [6:0] A_SET = 7'h44, A_CLR = 7'h45, A_EOI = 7'h46, A_DBG = 7'h47;
  localparam logic [6:0] A_SPUR = 7'h48, A_IVEC = 7'h49, A_FVEC = 7'h4A, A_TOP = 7'h4B;
  localparam logic [6:0] A_PEND = 7'h4C, A_MASK = 7'h4D, A_FORCE = 7'h4E, A_CORE = 7'h4F;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n, bus_wr, bus_rd;
  logic [31:0] src_i, bus_wdata, bus_rdata;
  logic [6:0]  bus_addr;
  logic        irq_o, fiq_o;

  prio_vec_intc i_prio_vec_intc (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .fiq_o(fiq_o));

  typedef struct {
    string       tag;
    bit          is_out;
    logic [31:0] exp;
  } item_t;
  item_t sbq[$];
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  int          m_prio [32];
  logic [31:0] m_vec  [32];
  logic [31:0] m_edge, m_pend, m_mask, m_force, m_spur, m_sq, src_v;
  logic [1:0]  m_dbg;
  int          m_ssrc [8];
  int          m_spri [8];
  int          m_dep, w_id, w_pri;
  bit          m_irq, m_fiq;

  task automatic m_eval();
    logic [31:0] rq, arb;
    int best;
    rq  = m_pend & m_mask;
    arb = rq & ~(m_force | 32'h1);
    w_id = 0;
    best = -1;
    for (int i = 1; i < 32; i++)
      if (arb[i] && m_prio[i] > best) begin
        w_id = i;
        best = m_prio[i];
      end
    w_pri = (best < 0) ? 0 : best;
    m_fiq = !m_dbg[1] && |(rq & (m_force | 32'h1));
    m_irq = !m_dbg[1] && |arb && (m_dep == 0 || w_pri > m_spri[m_dep - 1]);
  endtask

  function automatic logic [31:0] m_read(input int a);
    if (a < 32) return {26'b0, m_edge[a], 2'b0, 3'(m_prio[a])};
    if (a < 64) return m_vec[a - 32];
    case (7'(a))
      A_IVEC:  return (w_id == 0) ? m_spur : m_vec[w_id];
      A_FVEC:  return (m_pend[0] || |(m_pend & m_force)) ? m_vec[0] : m_spur;
      A_TOP:   return (m_dep == 0) ? 32'h0 : 32'(m_ssrc[m_dep - 1]);
      A_PEND:  return m_pend;
      A_MASK:  return m_mask;
      A_FORCE: return m_force;
      A_CORE:  return {30'b0, m_irq, m_fiq};
      A_DBG:   return {30'b0, m_dbg};
      A_SPUR:  return m_spur;
      default: return 32'h0;
    endcase
  endfunction

  task automatic cyc(input bit wr, input bit rd, input logic [6:0] a,
                     input logic [31:0] d, input string tag);
    logic [31:0] pn;
    bit push;
    item_t it;
    @(negedge clk);
    src_i = src_v; bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d;
    m_eval();
    it.tag = "R6/R7/R8 outputs"; it.is_out = 1; it.exp = {30'b0, m_irq, m_fiq};
    sbq.push_back(it);
    if (rd) begin
      it.tag = tag; it.is_out = 0; it.exp = m_read(int'(a));
      sbq.push_back(it);
    end
    pn = m_pend;
    push = m_dbg[0] ? (wr && a == A_IVEC) : (rd && a == A_IVEC);
    if (push && m_dep < 8 && w_id != 0) begin
      m_ssrc[m_dep] = w_id; m_spri[m_dep] = w_pri; m_dep++;
      if (m_edge[w_id]) pn[w_id] = 1'b0;
    end
    if (rd && a == A_FVEC && m_pend[0]) pn[0] = 1'b0;
    if (wr) begin
      case (a)
        A_EN:    m_mask  = m_mask | d;
        A_DIS:   m_mask  = m_mask & ~d;
        A_FEN:   m_force = m_force | d;
        A_FDIS:  m_force = m_force & ~d;
        A_SET:   pn = pn | (d & m_edge);
        A_CLR:   pn = pn & ~(d & m_edge);
        A_EOI:   if (m_dep > 0) m_dep--;
        A_DBG:   m_dbg = d[1:0];
        A_SPUR:  m_spur = d;
        default: ;
      endcase
    end
    pn = pn | (src_v & ~m_sq & m_edge);
    pn = (pn & m_edge) | (src_v & ~m_edge);
    if (wr && a < 32) begin m_prio[a] = int'(d[2:0]); m_edge[a] = d[5]; end
    if (wr && a >= 32 && a < 64) m_vec[a - 32] = d;
    m_pend = pn;
    m_sq = src_v;
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    cyc(1, 0, a, d, "");
  endtask
  task automatic rd(input logic [6:0] a, input string tag);
    cyc(0, 1, a, 32'h0, tag);
  endtask

  always @(negedge clk) begin
    #1;
    while (sbq.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = sbq.pop_front();
      act = it.is_out ? {30'b0, irq_o, fiq_o} : bus_rdata;
      n_chk++;
      if (act !== it.exp) begin
        n_bad++;
        $display("FAIL %s: actual %h expected %h at %0t", it.tag, act, it.exp, $time);
      end
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; src_i = '0; bus_wr = 0; bus_rd = 0; bus_addr = '0; bus_wdata = '0;
    for (int i = 0; i < 32; i++) begin m_prio[i] = 0; m_vec[i] = '0; end
    for (int i = 0; i < 8; i++) begin m_ssrc[i] = 0; m_spri[i] = 0; end
    m_edge = '0; m_pend = '0; m_mask = '0; m_force = '0; m_spur = '0; m_sq = '0;
    m_dbg = '0; m_dep = 0; src_v = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    rd(A_CORE, "R1 core"); rd(A_TOP, "R1 top"); rd(A_IVEC, "R1 ivec");
    rd(A_PEND, "R1 pend"); rd(A_MASK, "R1 mask"); rd(A_FORCE, "R1 force");
    rd(A_DBG, "R1 dbg"); rd(A_SPUR, "R1 spur"); rd(7'd3, "R1 mode"); rd(7'd35, "R1 vec");

    // R2 mode fields
    wr(7'd4, 32'hFFFF_FFFF); rd(7'd4, "R2 mode readback");
    wr(7'd5, 32'h3); wr(7'd7, 32'h6); wr(7'd10, 32'h22);
    wr(7'd12, 32'h4); wr(7'd13, 32'h4); wr(7'd0, 32'h20);
    rd(7'd10, "R2 edge prio");
    for (int i = 0; i < 32; i++) wr(7'(32 + i), 32'hA000 + 32'(i));
    wr(A_SPUR, 32'hDEAD); rd(7'd63, "R2 vector");

    // R3 pending behaviour
    src_v[5] = 1; wr(A_EN, 32'h34A1); rd(A_PEND, "R3 level high");
    src_v[5] = 0; rd(A_PEND, "R3 level low");
    src_v[10] = 1; rd(A_PEND, "R3 edge rise");
    src_v[10] = 0; rd(A_PEND, "R3 edge held");

    // R4 commands
    src_v[5] = 1; wr(A_CLR, 32'hFFFF_FFFF); rd(A_PEND, "R4 clear edge only");
    wr(A_SET, 32'h0000_0440); rd(A_PEND, "R4 set edge only");
    wr(A_DIS, 32'h0000_0080); rd(A_MASK, "R4 disable");
    wr(A_EN, 32'h0000_0080); rd(A_MASK, "R4 enable");
    wr(A_CLR, 32'h400);

    // R5 arbitration and R10 protected fetch
    src_v[12] = 1; src_v[13] = 1;
    wr(A_DBG, 32'h1); rd(A_IVEC, "R5 tie lowest wins"); rd(A_TOP, "R10 no push on read");
    wr(A_IVEC, 32'h0); rd(A_TOP, "R10 write pushes");
    wr(A_EOI, 0); wr(A_DBG, 32'h0);

    // R7 nesting and R9 fetch push
    rd(A_IVEC, "R9 fetch pushes"); rd(A_CORE, "R7 equal prio blocked");
    src_v[7] = 1; rd(A_CORE, "R7 higher prio raises");
    rd(A_IVEC, "R9 nested fetch"); rd(A_TOP, "R12 top nested");
    wr(A_EOI, 0); rd(A_TOP, "R12 pop");
    wr(A_EOI, 0); rd(A_TOP, "R12 empty");
    wr(A_EOI, 0); rd(A_TOP, "R12 pop on empty ignored");
    src_v[7] = 0;

    // R6 and R13 fast path
    wr(A_FEN, 32'h2000); rd(A_CORE, "R6 forced raises fast");
    rd(A_FVEC, "R13 forced fetch"); rd(A_PEND, "R13 no side effect");
    rd(A_IVEC, "R5 forced excluded");
    wr(A_FDIS, 32'h2000);
    src_v[0] = 1; rd(A_CORE, "R6 source 0");
    src_v[0] = 0; rd(A_FVEC, "R13 source 0 fetch"); rd(A_PEND, "R13 source 0 cleared");
    rd(A_FVEC, "R13 spurious");

    // R8 general mask
    wr(A_FEN, 32'h2000); wr(A_DBG, 32'h2); rd(A_CORE, "R8 masked");
    wr(A_DBG, 32'h0); rd(A_CORE, "R8 unmasked"); wr(A_FDIS, 32'h2000);

    // R11 stack bound, edge ack, source 0 never pushed
    src_v[10] = 1; wr(A_SET, 32'h0); src_v[10] = 0;
    wr(7'd10, 32'h27); rd(A_IVEC, "R11 edge winner"); rd(A_PEND, "R11 edge cleared");
    wr(A_EOI, 0);
    for (int k = 0; k < 10; k++) rd(A_IVEC, "R11 repeated push");
    rd(A_TOP, "R11 top when full");
    for (int k = 0; k < 9; k++) begin wr(A_EOI, 0); rd(A_TOP, "R12 unwind"); end
    src_v = '0; wr(A_CLR, 32'hFFFF_FFFF); rd(A_IVEC, "R9 spurious"); rd(A_TOP, "R11 no push of 0");

    // randomized phase
    for (int n = 0; n < 4000; n++) begin
      int op;
      logic [6:0] a;
      logic [31:0] d;
      op = int'($urandom % 5);
      a = 7'($urandom_range(0, 85));
      d = $urandom;
      if (a == A_DBG) d = {30'b0, ($urandom % 4 == 0) ? 2'b10 : 2'(d[0])};
      if ($urandom % 6 == 0) src_v[$urandom % 32] ^= 1'b1;
      if (op == 0) cyc(0, 0, a, 32'h0, "");
      else if (op == 1) cyc(1, 0, a, d, "");
      else if (op == 2) cyc(1, 0, ($urandom % 2) ? A_EOI : A_IVEC, d, "");
      else cyc(0, 1, a, 32'h0, "R3 R5 R9 R13 random read");
    end

    @(negedge clk); #2;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule